// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block sits between a host bus and the array engine of an asynchronous NOR-style memory with 16-bit words. Each host write cycle presents an address and a data word, and the low byte of that word is taken as a command code. The decoder works through one-cycle, two-cycle and variable-length command sequences. It chooses which source the host's reads return: array contents, identifier codes, query data or the status byte. When a sequence is accepted, it raises a one-cycle operation request, carrying an address and data, toward the array engine. That engine is abstracted as a single busy input.

The decoder also holds a lock bit and a lock-down bit for each block. It rejects erase and program requests aimed at locked blocks. It checks that both writes of a two-cycle command use the same address. It counts the words of a page-buffer load. It handles suspend and resume of an operation in progress. Any rejected sequence sets an error flag in the status byte and switches reads to status mode.

Top module: `nor_cmd_front`

## Requirements
- R1: After reset the read mode is array (0), no request is pending, every block is locked, no block is locked down, and the status byte reads 80h while the engine is idle.
- R2: A single write of FFh, 90h, 98h or 70h sets the read mode to 0 (array), 1 (identifier), 2 (query) or 3 (status) respectively, starting with the next cycle.
- R3: A write of 50h clears the sequence-error bit (status bit 4) and the lock-error bit (status bit 1).
- R4: The pair 20h then D0h, written to one address in an unlocked block, issues one request of kind 1 (block erase) at that address. The pair 30h then D0h issues kind 2 (chip erase) only when no block is locked; otherwise it sets lock error. Every erase or program command switches the read mode to status.
- R5: 40h or 10h, followed by a write, issues kind 3 (program) with that second write's address and data word. C0h followed by a write issues kind 4 (one-time-programmable area) in the same way.
- R6: If the address of the second write of a two-cycle command differs from the address of the first, the decoder sets status bit 4, issues no request and switches to status mode.
- R7: An unknown first byte, or an invalid second byte after 20h, 30h or 60h, sets status bit 4 and issues no request.
- R8: An erase or program (kinds 1, 3, 6) aimed at a locked block issues no request and sets status bit 1.
- R9: After 60h, a second byte of 01h locks the block, D0h unlocks it and 2Fh locks it down. A locked-down block refuses unlock (status bit 1 is set instead) until reset.
- R10: The pair 60h then 04h loads the partition configuration output with the address of the write.
- R11: A page-buffer load proceeds in four stages. E8h comes first. The next write's data is N-1, which must be below the buffer depth. Then come N writes at consecutive addresses from the first address, each issuing kind 5 with its address and data. The sequence ends with D0h to the same block, which issues kind 6 with data N at the first address. An out-of-range count or an out-of-order address sets status bit 4.
- R12: B0h while the engine is busy issues kind 7 (suspend) and sets status bit 6. D0h while suspended issues kind 8 (resume) and clears bit 6. B0h while the engine is idle issues nothing.
- R13: Status bit 7 reads the inverse of the engine busy input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write cycle strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 16 | Host write data; low byte is the command code |
| eng_busy | input | 1 | Array engine busy |
| rd_mode | output | 2 | Read source: 0 array, 1 identifier, 2 query, 3 status |
| status_byte | output | 8 | Status register value |
| pcr_q | output | ADDR_W | Partition configuration register |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 4 | Request kind code |
| op_addr | output | ADDR_W | Request address |
| op_data | output | 16 | Request data |

## Verification
The hardest state to reach is a page-buffer load that must reach its confirm stage with exactly N sequential words, while the target block's lock bit is also in a known state. A lock-down that must persist until reset is equally hard to reach. Directed sequences first unlock a block and then run a full four-stage load. They then corrupt the count and the address order. They also set lock-down and try to unlock, and then apply a reset. A seeded random phase toggles lock bits on random blocks and then fires erases and programs at random addresses inside them. Each outcome is predicted from a bench-side lock model.

// File: rtl/nfc_pkg.sv
// Shared codes for the flash command decoder.
// Assumes: command codes sit in the low byte of a host write word.
package nfc_pkg;
    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_QUERY  = 2'd2,
        RM_STATUS = 2'd3
    } rd_mode_e;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_ERASE  = 4'd1,
        OP_CHIP   = 4'd2,
        OP_PROG   = 4'd3,
        OP_OTP    = 4'd4,
        OP_BUFLD  = 4'd5,
        OP_PAGE   = 4'd6,
        OP_SUSP   = 4'd7,
        OP_RESUME = 4'd8
    } op_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT2,
        S_PB_CNT,
        S_PB_DATA,
        S_PB_CONF
    } seq_state_e;

    localparam logic [7:0] C_ARRAY  = 8'hFF;
    localparam logic [7:0] C_IDENT  = 8'h90;
    localparam logic [7:0] C_QUERY  = 8'h98;
    localparam logic [7:0] C_STAT   = 8'h70;
    localparam logic [7:0] C_CLRST  = 8'h50;
    localparam logic [7:0] C_ERASE  = 8'h20;
    localparam logic [7:0] C_CHIP   = 8'h30;
    localparam logic [7:0] C_PROGA  = 8'h40;
    localparam logic [7:0] C_PROGB  = 8'h10;
    localparam logic [7:0] C_PAGE   = 8'hE8;
    localparam logic [7:0] C_LOCKP  = 8'h60;
    localparam logic [7:0] C_OTP    = 8'hC0;
    localparam logic [7:0] C_SUSP   = 8'hB0;
    localparam logic [7:0] C_CONF   = 8'hD0;
    localparam logic [7:0] C_LKSET  = 8'h01;
    localparam logic [7:0] C_LKDOWN = 8'h2F;
    localparam logic [7:0] C_PCR    = 8'h04;
endpackage

// File: rtl/nfc_lock_bank.sv
// Per-block lock and lock-down bits.
// Assumes: set/clear pulses last one cycle; an unlock is refused for a
// locked-down block; lock-down is cleared only by reset.
module nfc_lock_bank #(
    parameter int NBLK     = 8,
    parameter bit LOCK_RST = 1'b1,
    localparam int BW      = $clog2(NBLK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_set,
    input  logic            lk_clr,
    input  logic            lk_down,
    input  logic [BW-1:0]   blk,
    output logic [NBLK-1:0] lock_v,
    output logic [NBLK-1:0] down_v
);
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        // Update the lock bits of one block from decoded lock commands.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_v[b] <= LOCK_RST;
                down_v[b] <= 1'b0;
            end else if (blk == BW'(b)) begin
                if (lk_set)
                    lock_v[b] <= 1'b1;
                else if (lk_clr && !down_v[b])
                    lock_v[b] <= 1'b0;
                if (lk_down)
                    down_v[b] <= 1'b1;
            end
        end

        p_down_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(down_v[b]) |-> (down_v[b] && !$fell(lock_v[b])));
    end
endmodule

// File: rtl/nfc_status.sv
// Status byte: ready, suspended, sequence error and lock error.
// Assumes: set and clear pulses never coincide for the same flag.
module nfc_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eng_busy,
    input  logic       seq_err,
    input  logic       lock_err,
    input  logic       clr_err,
    input  logic       set_susp,
    input  logic       clr_susp,
    output logic       susp_q,
    output logic [7:0] status_byte
);
    logic seq_q;
    logic lck_q;

    // Hold the sticky error flags and the suspend flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= 1'b0;
            lck_q  <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            if (clr_err) begin
                seq_q <= 1'b0;
                lck_q <= 1'b0;
            end else begin
                if (seq_err)  seq_q <= 1'b1;
                if (lock_err) lck_q <= 1'b1;
            end
            if (set_susp)      susp_q <= 1'b1;
            else if (clr_susp) susp_q <= 1'b0;
        end
    end

    // Assemble the readable status byte.
    always_comb status_byte = {~eng_busy, susp_q, 1'b0, seq_q, 2'b00, lck_q, 1'b0};

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> (status_byte[4] == 1'b0 && status_byte[1] == 1'b0));
endmodule

// File: rtl/nfc_seq_fsm.sv
// Command sequence walker: decodes host writes, checks addresses and locks,
// drives read mode and registered one-cycle operation requests.
// Assumes: lock state of chk_blk is presented combinationally by the bank.
module nfc_seq_fsm
    import nfc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BLK_W    = 3,
    parameter int PB_DEPTH = 16,
    localparam int CW      = $clog2(PB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              eng_busy,
    input  logic              susp_q,
    input  logic              chk_locked,
    input  logic              chk_down,
    input  logic              any_locked,
    output logic [BLK_W-1:0]  chk_blk,
    output logic              seq_err,
    output logic              lock_err,
    output logic              clr_err,
    output logic              set_susp,
    output logic              clr_susp,
    output logic              lk_set,
    output logic              lk_clr,
    output logic              lk_down,
    output logic              pcr_we,
    output rd_mode_e          rd_mode,
    output logic              op_valid,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data
);
    seq_state_e        st, st_n;
    rd_mode_e          mode_n;
    logic [7:0]        cmd, cmd_n;
    logic [ADDR_W-1:0] a1, a1_n;
    logic [CW-1:0]     cnt, cnt_n, idx, idx_n;
    logic              ov_n;
    op_kind_e          ok_n;
    logic [ADDR_W-1:0] oa_n;
    logic [15:0]       od_n;
    logic [7:0]        d;

    assign d = wr_data[7:0];

    // Decode one host write against the current sequence stage.
    always_comb begin
        st_n = st;  mode_n = rd_mode; cmd_n = cmd; a1_n = a1;
        cnt_n = cnt; idx_n = idx;
        ov_n = 1'b0; ok_n = OP_NONE; oa_n = wr_addr; od_n = wr_data;
        seq_err = 1'b0; lock_err = 1'b0; clr_err = 1'b0;
        set_susp = 1'b0; clr_susp = 1'b0;
        lk_set = 1'b0; lk_clr = 1'b0; lk_down = 1'b0; pcr_we = 1'b0;
        chk_blk = (st == S_PB_CONF) ? a1[ADDR_W-1 -: BLK_W] : wr_addr[ADDR_W-1 -: BLK_W];
        if (wr_en) begin
            unique case (st)
                S_IDLE: begin
                    cmd_n = d;
                    a1_n  = wr_addr;
                    case (d)
                        C_ARRAY: mode_n = RM_ARRAY;
                        C_IDENT: mode_n = RM_IDENT;
                        C_QUERY: mode_n = RM_QUERY;
                        C_STAT:  mode_n = RM_STATUS;
                        C_CLRST: clr_err = 1'b1;
                        C_ERASE, C_CHIP, C_PROGA, C_PROGB, C_LOCKP, C_OTP:
                            st_n = S_WAIT2;
                        C_PAGE:  st_n = S_PB_CNT;
                        C_SUSP: begin
                            mode_n = RM_STATUS;
                            if (eng_busy && !susp_q) begin
                                ov_n = 1'b1; ok_n = OP_SUSP; set_susp = 1'b1;
                            end
                        end
                        C_CONF: begin
                            if (susp_q) begin
                                ov_n = 1'b1; ok_n = OP_RESUME; clr_susp = 1'b1;
                                mode_n = RM_STATUS;
                            end else begin
                                seq_err = 1'b1;
                            end
                        end
                        default: seq_err = 1'b1;
                    endcase
                end
                S_WAIT2: begin
                    st_n = S_IDLE;
                    if (wr_addr != a1) begin
                        seq_err = 1'b1;
                    end else begin
                        case (cmd)
                            C_ERASE: begin
                                mode_n = RM_STATUS;
                                if (d != C_CONF)   seq_err  = 1'b1;
                                else if (chk_locked) lock_err = 1'b1;
                                else begin ov_n = 1'b1; ok_n = OP_ERASE; end
                            end
                            C_CHIP: begin
                                mode_n = RM_STATUS;
                                if (d != C_CONF)   seq_err  = 1'b1;
                                else if (any_locked) lock_err = 1'b1;
                                else begin ov_n = 1'b1; ok_n = OP_CHIP; end
                            end
                            C_PROGA, C_PROGB: begin
                                mode_n = RM_STATUS;
                                if (chk_locked) lock_err = 1'b1;
                                else begin ov_n = 1'b1; ok_n = OP_PROG; end
                            end
                            C_OTP: begin
                                mode_n = RM_STATUS;
                                ov_n = 1'b1; ok_n = OP_OTP;
                            end
                            default: begin
                                case (d)
                                    C_LKSET:  lk_set = 1'b1;
                                    C_CONF: begin
                                        if (chk_down) lock_err = 1'b1;
                                        else          lk_clr = 1'b1;
                                    end
                                    C_LKDOWN: lk_down = 1'b1;
                                    C_PCR:    pcr_we = 1'b1;
                                    default:  seq_err = 1'b1;
                                endcase
                            end
                        endcase
                    end
                end
                S_PB_CNT: begin
                    if (wr_data >= 16'(PB_DEPTH)) begin
                        seq_err = 1'b1; st_n = S_IDLE;
                    end else begin
                        cnt_n = wr_data[CW-1:0]; idx_n = '0; st_n = S_PB_DATA;
                    end
                end
                S_PB_DATA: begin
                    if (wr_addr != a1 + ADDR_W'(idx)) begin
                        seq_err = 1'b1; st_n = S_IDLE;
                    end else begin
                        ov_n = 1'b1; ok_n = OP_BUFLD;
                        if (idx == cnt) st_n = S_PB_CONF;
                        else            idx_n = idx + 1'b1;
                    end
                end
                S_PB_CONF: begin
                    st_n = S_IDLE;
                    mode_n = RM_STATUS;
                    if (d != C_CONF || wr_addr[ADDR_W-1 -: BLK_W] != a1[ADDR_W-1 -: BLK_W])
                        seq_err = 1'b1;
                    else if (chk_locked)
                        lock_err = 1'b1;
                    else begin
                        ov_n = 1'b1; ok_n = OP_PAGE; oa_n = a1;
                        od_n = 16'(cnt) + 16'd1;
                    end
                end
                default: st_n = S_IDLE;
            endcase
            if (seq_err || lock_err) mode_n = RM_STATUS;
        end
    end

    // Register sequence state, read mode and the request outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; rd_mode <= RM_ARRAY; cmd <= '0; a1 <= '0;
            cnt <= '0; idx <= '0;
            op_valid <= 1'b0; op_kind <= OP_NONE; op_addr <= '0; op_data <= '0;
        end else begin
            st <= st_n; rd_mode <= mode_n; cmd <= cmd_n; a1 <= a1_n;
            cnt <= cnt_n; idx <= idx_n;
            op_valid <= ov_n; op_kind <= ok_n; op_addr <= oa_n; op_data <= od_n;
        end
    end

    p_op_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(wr_en));
    p_op_kind_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_kind != OP_NONE));
endmodule

// File: rtl/nor_cmd_front.sv
// Top of the flash command decoder: sequence walker, lock bank, status
// byte and partition configuration register.
// Assumes: block number is the upper BLK_W address bits.
module nor_cmd_front
    import nfc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BLK_WORDS = 32,
    parameter int PB_DEPTH  = 16,
    parameter bit LOCK_RST  = 1'b1,
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int BLK_W    = ADDR_W - OFF_W,
    localparam int NBLK     = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              eng_busy,
    output logic [1:0]        rd_mode,
    output logic [7:0]        status_byte,
    output logic [ADDR_W-1:0] pcr_q,
    output logic              op_valid,
    output logic [3:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data
);
    logic [BLK_W-1:0] chk_blk;
    logic [NBLK-1:0]  lock_v, down_v;
    logic seq_err, lock_err, clr_err, set_susp, clr_susp;
    logic lk_set, lk_clr, lk_down, pcr_we, susp_q;
    rd_mode_e mode_e;
    op_kind_e kind_e;

    nfc_seq_fsm #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PB_DEPTH(PB_DEPTH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .eng_busy(eng_busy), .susp_q(susp_q),
        .chk_locked(lock_v[chk_blk]), .chk_down(down_v[chk_blk]),
        .any_locked(|lock_v), .chk_blk(chk_blk),
        .seq_err(seq_err), .lock_err(lock_err), .clr_err(clr_err),
        .set_susp(set_susp), .clr_susp(clr_susp),
        .lk_set(lk_set), .lk_clr(lk_clr), .lk_down(lk_down), .pcr_we(pcr_we),
        .rd_mode(mode_e), .op_valid(op_valid), .op_kind(kind_e),
        .op_addr(op_addr), .op_data(op_data)
    );

    nfc_lock_bank #(.NBLK(NBLK), .LOCK_RST(LOCK_RST)) u_lock (
        .clk(clk), .rst_n(rst_n), .lk_set(lk_set), .lk_clr(lk_clr),
        .lk_down(lk_down), .blk(chk_blk), .lock_v(lock_v), .down_v(down_v)
    );

    nfc_status u_stat (
        .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .seq_err(seq_err),
        .lock_err(lock_err), .clr_err(clr_err), .set_susp(set_susp),
        .clr_susp(clr_susp), .susp_q(susp_q), .status_byte(status_byte)
    );

    assign rd_mode = mode_e;
    assign op_kind = kind_e;

    // Partition configuration register, loaded from the address bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      pcr_q <= '0;
        else if (pcr_we) pcr_q <= wr_addr;
    end

    p_unlocked_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (kind_e == OP_ERASE || kind_e == OP_PROG || kind_e == OP_PAGE))
        |-> !lock_v[op_addr[ADDR_W-1 -: BLK_W]]);
    p_err_to_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[4]) |-> (mode_e == RM_STATUS));
    p_suspend_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && kind_e == OP_SUSP) |-> $past(eng_busy));
endmodule

// File: tb/nor_cmd_front_tb.sv
module nor_cmd_front_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        eng_busy = 1'b0;
    logic [1:0]  rd_mode;
    logic [7:0]  status_byte;
    logic [7:0]  pcr_q;
    logic        op_valid;
    logic [3:0]  op_kind;
    logic [7:0]  op_addr;
    logic [15:0] op_data;

    int n_run = 0;
    int n_fail = 0;
    bit model_lock [8];

    always #2 clk = ~clk;

    nor_cmd_front u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .eng_busy(eng_busy), .rd_mode(rd_mode),
        .status_byte(status_byte), .pcr_q(pcr_q), .op_valid(op_valid),
        .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data)
    );

    function automatic logic [2:0] blk_of(input logic [7:0] a);
        return a[7:5];
    endfunction

    function automatic logic [7:0] exp_stat(input bit busy, input bit susp,
                                            input bit serr, input bit lerr);
        return {~busy, susp, 1'b0, serr, 2'b00, lerr, 1'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < 8; b++) model_lock[b] = 1'b1;
    endtask

    task automatic unlock(input logic [7:0] a);
        wr(a, 16'h0060); wr(a, 16'h00D0);
        model_lock[blk_of(a)] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", rd_mode, 0);
        chk("R1 status", status_byte, 8'h80);
        chk("R1 op", op_valid, 0);
        // R13 ready bit follows busy
        eng_busy = 1'b1; #1;
        chk("R13 busy", status_byte, 8'h00);
        eng_busy = 1'b0; #1;
        chk("R13 idle", status_byte, 8'h80);
        // R2 read modes
        wr(8'h00, 16'h0090); chk("R2 ident", rd_mode, 1);
        wr(8'h00, 16'h0098); chk("R2 query", rd_mode, 2);
        wr(8'h00, 16'h0070); chk("R2 status", rd_mode, 3);
        wr(8'h00, 16'h00FF); chk("R2 array", rd_mode, 0);
        // R8 + R1: block locked at reset
        wr(8'h45, 16'h0020); wr(8'h45, 16'h00D0);
        chk("R8 no op", op_valid, 0);
        chk("R8 lock err", status_byte, exp_stat(0, 0, 0, 1));
        chk("R4 mode", rd_mode, 3);
        // R3 clear
        wr(8'h00, 16'h0050);
        chk("R3 cleared", status_byte, 8'h80);
        // R9 unlock, R4 erase
        unlock(8'h45);
        chk("R9 unlock no op", op_valid, 0);
        wr(8'h00, 16'h00FF);
        wr(8'h45, 16'h0020); wr(8'h45, 16'h00D0);
        chk("R4 erase valid", op_valid, 1);
        chk("R4 erase kind", op_kind, 1);
        chk("R4 erase addr", op_addr, 8'h45);
        chk("R4 erase mode", rd_mode, 3);
        @(negedge clk);
        chk("R4 one cycle", op_valid, 0);
        // R5 program both prefixes and OTP
        wr(8'h4A, 16'h0040); wr(8'h4A, 16'h1234);
        chk("R5 prog kind", op_kind, 3);
        chk("R5 prog data", op_data, 16'h1234);
        wr(8'h4B, 16'h0010); wr(8'h4B, 16'hBEEF);
        chk("R5 prog alt", {op_valid, op_kind, op_addr, op_data}, {1'b1, 4'd3, 8'h4B, 16'hBEEF});
        wr(8'h10, 16'h00C0); wr(8'h10, 16'h5A5A);
        chk("R5 otp", {op_valid, op_kind, op_data}, {1'b1, 4'd4, 16'h5A5A});
        // R6 address mismatch
        wr(8'h45, 16'h0020); wr(8'h46, 16'h00D0);
        chk("R6 no op", op_valid, 0);
        chk("R6 status", status_byte, exp_stat(0, 0, 1, 0));
        wr(8'h00, 16'h0050);
        // R7 bad second byte, unknown first byte
        wr(8'h45, 16'h0020); wr(8'h45, 16'h00FF);
        chk("R7 bad second", {op_valid, status_byte}, {1'b0, exp_stat(0, 0, 1, 0)});
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0077);
        chk("R7 unknown", {op_valid, status_byte}, {1'b0, exp_stat(0, 0, 1, 0)});
        wr(8'h00, 16'h0050);
        wr(8'h45, 16'h0060); wr(8'h45, 16'h0033);
        chk("R7 bad lock byte", status_byte, exp_stat(0, 0, 1, 0));
        wr(8'h00, 16'h0050);
        // R4 chip erase blocked, then allowed
        wr(8'h00, 16'h0030); wr(8'h00, 16'h00D0);
        chk("R4 chip locked", {op_valid, status_byte}, {1'b0, exp_stat(0, 0, 0, 1)});
        wr(8'h00, 16'h0050);
        for (int b = 0; b < 8; b++) unlock(8'(b * 32));
        wr(8'h00, 16'h0030); wr(8'h00, 16'h00D0);
        chk("R4 chip ok", {op_valid, op_kind}, {1'b1, 4'd2});
        // R11 page buffer, N=4 in block 3
        wr(8'h60, 16'h00E8); wr(8'h60, 16'd3);
        for (int i = 0; i < 4; i++) begin
            wr(8'(8'h60 + i), 16'(16'hA000 + i));
            chk("R11 load", {op_valid, op_kind, op_addr, op_data},
                {1'b1, 4'd5, 8'(8'h60 + i), 16'(16'hA000 + i)});
        end
        wr(8'h61, 16'h00D0);
        chk("R11 page", {op_valid, op_kind, op_addr, op_data}, {1'b1, 4'd6, 8'h60, 16'd4});
        wr(8'h60, 16'h00E8); wr(8'h60, 16'd1); wr(8'h62, 16'h1111);
        chk("R11 bad order", {op_valid, status_byte}, {1'b0, exp_stat(0, 0, 1, 0)});
        wr(8'h00, 16'h0050);
        wr(8'h60, 16'h00E8); wr(8'h60, 16'd16);
        chk("R11 big count", {op_valid, status_byte}, {1'b0, exp_stat(0, 0, 1, 0)});
        wr(8'h00, 16'h0050);
        // R8 page buffer to locked block
        wr(8'h60, 16'h0060); wr(8'h60, 16'h0001);
        model_lock[3] = 1'b1;
        wr(8'h60, 16'h00E8); wr(8'h60, 16'd0); wr(8'h60, 16'h2222); wr(8'h60, 16'h00D0);
        chk("R8 page locked", {op_valid, status_byte}, {1'b0, exp_stat(0, 0, 0, 1)});
        wr(8'h00, 16'h0050);
        // R10 partition register
        wr(8'h9C, 16'h0060); wr(8'h9C, 16'h0004);
        chk("R10 pcr", pcr_q, 8'h9C);
        // R9 lock-down blocks unlock until reset
        wr(8'h45, 16'h0060); wr(8'h45, 16'h002F);
        wr(8'h45, 16'h0060); wr(8'h45, 16'h0001);
        wr(8'h45, 16'h0060); wr(8'h45, 16'h00D0);
        chk("R9 unlock refused", status_byte, exp_stat(0, 0, 0, 1));
        wr(8'h00, 16'h0050);
        wr(8'h45, 16'h0020); wr(8'h45, 16'h00D0);
        chk("R9 still locked", {op_valid, status_byte}, {1'b0, exp_stat(0, 0, 0, 1)});
        // R12 suspend / resume
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h00B0);
        chk("R12 idle suspend", {op_valid, status_byte}, {1'b0, 8'h80});
        eng_busy = 1'b1;
        wr(8'h00, 16'h00B0);
        chk("R12 suspend", {op_valid, op_kind, status_byte}, {1'b1, 4'd7, 8'h40});
        wr(8'h00, 16'h00D0);
        chk("R12 resume", {op_valid, op_kind, status_byte}, {1'b1, 4'd8, 8'h00});
        eng_busy = 1'b0;
        // R9 reset clears lock-down
        do_reset();
        unlock(8'h45);
        wr(8'h45, 16'h0020); wr(8'h45, 16'h00D0);
        chk("R9 after reset", {op_valid, op_kind}, {1'b1, 4'd1});
        // random phase: R8 / R4 / R5 against lock model
        for (int it = 0; it < 80; it++) begin
            logic [7:0] a;
            bit do_lock, do_prog;
            logic [15:0] dv;
            a = 8'($urandom);
            do_lock = 1'($urandom);
            do_prog = 1'($urandom);
            dv = 16'($urandom);
            wr(a, 16'h0060); wr(a, do_lock ? 16'h0001 : 16'h00D0);
            model_lock[blk_of(a)] = do_lock;
            if (do_prog) begin
                wr(a, 16'h0040); wr(a, dv);
            end else begin
                wr(a, 16'h0020); wr(a, 16'h00D0);
            end
            if (model_lock[blk_of(a)])
                chk("R8 random", {op_valid, status_byte}, {1'b0, exp_stat(0, 0, 0, 1)});
            else if (do_prog)
                chk("R5 random", {op_valid, op_kind, op_addr, op_data}, {1'b1, 4'd3, a, dv});
            else
                chk("R4 random", {op_valid, op_kind, op_addr}, {1'b1, 4'd1, a});
            wr(8'h00, 16'h0050);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule